// File: doc/BRIEF.md
# Universal Registered Bus Transceiver

This block is a two-way register path between an A port and a B port. Data can move from A to B, from B to A, or both ways at once. Each direction has its own storage. Each 9-bit half of each direction has its own three controls: an active-low output enable, a latch enable and a capture clock. The storage element works in one of three ways. It is transparent while the latch enable is high. It holds its value while the latch enable is low and the capture clock stays at one level. It loads the input bus on a rising edge of the capture clock.

Tri-state pins are modelled as a data vector plus one active-high drive flag per half. A released half drives zeros on its data vector. The capture clocks are sampled by a fast system clock, and their rising edges are detected synchronously. A mode input sets how the halves are controlled. In split mode the two 9-bit halves run on their own controls. In wide mode the half-0 controls govern all 18 bits. A per-half flag reports contention, which occurs when both directions drive the same half.

Top module: `univ_bus_xcvr`

## Requirements
- R1: A synchronous reset (`rst` high at a `clk` edge) clears the storage of both directions to zero. Right after reset, with outputs enabled, the latch enable low and no clock edge, both ports read zero.
- R2: While a half's latch enable is high and its output enable is low, that half's output equals its input in the same cycle. This holds before any `clk` edge.
- R3: While the latch enable is low and the capture clock does not rise, the stored value and the driven output stay unchanged whatever the input bus does.
- R4: With the latch enable low, a capture-clock level of 1 seen at a `clk` edge, after a level of 0 at the previous edge, loads the input bus. The new value is on the output right after that edge. A falling edge loads nothing.
- R5: A half whose active-low output enable is 1 has its drive flag at 0 and reads zero on its data vector. With the enable at 0, the drive flag is 1.
- R6: The B-to-A direction follows R2 to R4 with its own controls. Its storage is separate, so activity in one direction never changes the value held by the other.
- R7: With `wide_mode`=0, half 0 (bits 8:0) uses control bit 0 and half 1 (bits 17:9) uses control bit 1. The two halves act independently.
- R8: With `wide_mode`=1, control bit 0 of each control input governs both halves, and control bit 1 is ignored.
- R9: `contention[h]` is 1 exactly when both directions' effective output enables for half h are low.
- R10: When the latch enable falls, the register keeps the input value that was present at the last `clk` edge while the latch enable was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all controls |
| rst | input | 1 | Synchronous reset, active high |
| wide_mode | input | 1 | 1: half-0 controls govern all bits |
| a_in | input | 18 | A-port input bus |
| b_in | input | 18 | B-port input bus |
| ab_oe_n | input | 2 | A-to-B active-low output enable per half |
| ab_le | input | 2 | A-to-B latch enable per half |
| ab_ck | input | 2 | A-to-B capture clock per half |
| ba_oe_n | input | 2 | B-to-A active-low output enable per half |
| ba_le | input | 2 | B-to-A latch enable per half |
| ba_ck | input | 2 | B-to-A capture clock per half |
| b_out | output | 18 | Data driven onto the B port |
| b_drv | output | 2 | B-port drive flag per half |
| a_out | output | 18 | Data driven onto the A port |
| a_drv | output | 2 | A-port drive flag per half |
| contention | output | 2 | Both directions driving a half |

## Verification
A stored word that is wrong appears on the port as soon as that half is driven with the latch enable low. A wrong capture shows in the first cycle after the clock edge that should have loaded it. A missed or false edge detection shows on the next hold cycle, where the output keeps a value it should have replaced or changes when it should hold. A control wrongly routed between halves shows as a 9-bit slice that changes or stays put when it should not. This is checked both in split mode and in wide mode.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    typedef struct packed {
        logic oe_n;
        logic le;
        logic ck;
    } dir_ctl_t;
endpackage

// File: rtl/xcvr_ctl_sel.sv
module xcvr_ctl_sel
    import xcvr_pkg::*;
#(
    parameter int NUM_HALVES = 2
) (
    input  logic                       wide_mode,
    input  dir_ctl_t [NUM_HALVES-1:0]  ctl_in,
    output dir_ctl_t [NUM_HALVES-1:0]  ctl_out
);
    // Half 0 always uses its own controls; higher halves borrow half 0 in wide mode.
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_sel
        if (h == 0) begin : g_base
            assign ctl_out[h] = ctl_in[0];
        end else begin : g_upper
            assign ctl_out[h] = wide_mode ? ctl_in[0] : ctl_in[h];
        end
    end
endmodule

// File: rtl/xcvr_dir_path.sv
module xcvr_dir_path
    import xcvr_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  dir_ctl_t     ctl,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         drv
);
    typedef struct packed {
        logic [W-1:0] store;
        logic         ck_prev;
    } path_st_t;

    path_st_t     st_d, st_q;
    logic         ck_rise;
    logic [W-1:0] path_val;

    always_comb begin
        st_d         = st_q;
        st_d.ck_prev = ctl.ck;
        ck_rise      = ctl.ck & ~st_q.ck_prev;
        if (rst) begin
            st_d.store = '0;
        end else if (ctl.le || ck_rise) begin
            st_d.store = din;
        end
        path_val = ctl.le ? din : st_q.store;
        drv      = ~ctl.oe_n;
        dout     = drv ? path_val : '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (st_q.store == '0));

    // R2
    transparent_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.le && !ctl.oe_n) |-> (dout == din));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.le && !(ctl.ck && !st_q.ck_prev)) |=> $stable(st_q.store));

    // R4
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.le && ctl.ck && !st_q.ck_prev) |=> (st_q.store == $past(din)));

    // R5
    release_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.oe_n |-> (!drv && dout == '0));
endmodule

// File: rtl/univ_bus_xcvr.sv
module univ_bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int HALF_W     = 9,
    parameter int NUM_HALVES = 2,
    localparam int TOT_W     = HALF_W * NUM_HALVES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wide_mode,
    input  logic [TOT_W-1:0]      a_in,
    input  logic [TOT_W-1:0]      b_in,
    input  logic [NUM_HALVES-1:0] ab_oe_n,
    input  logic [NUM_HALVES-1:0] ab_le,
    input  logic [NUM_HALVES-1:0] ab_ck,
    input  logic [NUM_HALVES-1:0] ba_oe_n,
    input  logic [NUM_HALVES-1:0] ba_le,
    input  logic [NUM_HALVES-1:0] ba_ck,
    output logic [TOT_W-1:0]      b_out,
    output logic [NUM_HALVES-1:0] b_drv,
    output logic [TOT_W-1:0]      a_out,
    output logic [NUM_HALVES-1:0] a_drv,
    output logic [NUM_HALVES-1:0] contention
);
    dir_ctl_t [NUM_HALVES-1:0] ab_raw, ba_raw, ab_eff, ba_eff;

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_pack
        assign ab_raw[h] = '{oe_n: ab_oe_n[h], le: ab_le[h], ck: ab_ck[h]};
        assign ba_raw[h] = '{oe_n: ba_oe_n[h], le: ba_le[h], ck: ba_ck[h]};
    end

    xcvr_ctl_sel #(.NUM_HALVES(NUM_HALVES)) i_ab_sel (
        .wide_mode (wide_mode),
        .ctl_in    (ab_raw),
        .ctl_out   (ab_eff)
    );

    xcvr_ctl_sel #(.NUM_HALVES(NUM_HALVES)) i_ba_sel (
        .wide_mode (wide_mode),
        .ctl_in    (ba_raw),
        .ctl_out   (ba_eff)
    );

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        xcvr_dir_path #(.W(HALF_W)) i_ab_path (
            .clk  (clk),
            .rst  (rst),
            .ctl  (ab_eff[h]),
            .din  (a_in[h*HALF_W +: HALF_W]),
            .dout (b_out[h*HALF_W +: HALF_W]),
            .drv  (b_drv[h])
        );

        xcvr_dir_path #(.W(HALF_W)) i_ba_path (
            .clk  (clk),
            .rst  (rst),
            .ctl  (ba_eff[h]),
            .din  (b_in[h*HALF_W +: HALF_W]),
            .dout (a_out[h*HALF_W +: HALF_W]),
            .drv  (a_drv[h])
        );

        assign contention[h] = ~ab_eff[h].oe_n & ~ba_eff[h].oe_n;

        // R9
        contention_chk: assert property (@(posedge clk) disable iff (rst)
            contention[h] == (a_drv[h] && b_drv[h]));

        // R8
        wide_follow_chk: assert property (@(posedge clk) disable iff (rst)
            wide_mode |-> (b_drv[h] == b_drv[0] && a_drv[h] == a_drv[0]));
    end
endmodule

// File: tb/test_univ_bus_xcvr.sv
module test_univ_bus_xcvr;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 12;

    typedef struct packed {
        logic [31:0] tag;
        logic        wide;
        logic [1:0]  ab_oe_n, ab_le, ab_ck, ba_oe_n, ba_le, ba_ck;
        logic [17:0] a, b;
        logic [17:0] exp_b;
        logic [1:0]  exp_bdrv;
        logic [17:0] exp_a;
        logic [1:0]  exp_adrv, exp_cont;
    } vec_t;

    // Rows are applied one per cycle after reset and checked just after the next clk edge.
    localparam vec_t VECS [0:NVEC-1] = '{
        '{"R2  ", 1'b0, 2'b00, 2'b11, 2'b00, 2'b11, 2'b00, 2'b00, 18'h12345, 18'h0ABCD, 18'h12345, 2'b11, 18'h0, 2'b00, 2'b00},
        '{"R10 ", 1'b0, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 18'h3FFFF, 18'h0ABCD, 18'h12345, 2'b11, 18'h0, 2'b00, 2'b00},
        '{"R4  ", 1'b0, 2'b00, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 18'h00F0F, 18'h0ABCD, 18'h00F0F, 2'b11, 18'h0, 2'b00, 2'b00},
        '{"R3  ", 1'b0, 2'b00, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 18'h11111, 18'h0ABCD, 18'h00F0F, 2'b11, 18'h0, 2'b00, 2'b00},
        '{"R4  ", 1'b0, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 18'h22222, 18'h0ABCD, 18'h00F0F, 2'b11, 18'h0, 2'b00, 2'b00},
        '{"R7  ", 1'b0, 2'b00, 2'b00, 2'b10, 2'b11, 2'b00, 2'b00, 18'h2AAAA, 18'h0ABCD, 18'h2AB0F, 2'b11, 18'h0, 2'b00, 2'b00},
        '{"R5  ", 1'b0, 2'b01, 2'b00, 2'b10, 2'b11, 2'b00, 2'b00, 18'h00000, 18'h0ABCD, 18'h2AA00, 2'b10, 18'h0, 2'b00, 2'b00},
        '{"R6  ", 1'b0, 2'b00, 2'b00, 2'b10, 2'b00, 2'b00, 2'b11, 18'h00000, 18'h3C3C3, 18'h2AB0F, 2'b11, 18'h3C3C3, 2'b11, 2'b11},
        '{"R8  ", 1'b1, 2'b10, 2'b00, 2'b00, 2'b11, 2'b00, 2'b11, 18'h15555, 18'h3C3C3, 18'h2AB0F, 2'b11, 18'h0, 2'b00, 2'b00},
        '{"R8  ", 1'b1, 2'b10, 2'b00, 2'b01, 2'b11, 2'b00, 2'b11, 18'h15555, 18'h3C3C3, 18'h15555, 2'b11, 18'h0, 2'b00, 2'b00},
        '{"R8  ", 1'b1, 2'b10, 2'b00, 2'b10, 2'b11, 2'b00, 2'b11, 18'h3FFFF, 18'h3C3C3, 18'h15555, 2'b11, 18'h0, 2'b00, 2'b00},
        '{"R5  ", 1'b1, 2'b01, 2'b00, 2'b10, 2'b11, 2'b00, 2'b11, 18'h3FFFF, 18'h3C3C3, 18'h00000, 2'b00, 18'h0, 2'b00, 2'b00}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wide_mode = 1'b0;
    logic [17:0] a_in = '0, b_in = '0;
    logic [1:0]  ab_oe_n = 2'b11, ab_le = 2'b00, ab_ck = 2'b00;
    logic [1:0]  ba_oe_n = 2'b11, ba_le = 2'b00, ba_ck = 2'b00;
    logic [17:0] b_out, a_out;
    logic [1:0]  b_drv, a_drv, contention;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    univ_bus_xcvr i_univ_bus_xcvr (
        .clk(clk), .rst(rst), .wide_mode(wide_mode),
        .a_in(a_in), .b_in(b_in),
        .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_ck(ab_ck),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_ck(ba_ck),
        .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv),
        .contention(contention)
    );

    task automatic check(input string req, input logic [59:0] act, input logic [59:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act b=%h bdrv=%b a=%h adrv=%b cont=%b exp b=%h bdrv=%b a=%h adrv=%b cont=%b",
                     req, act[59:42], act[41:40], act[39:22], act[21:20], act[19:18],
                     exp[59:42], exp[41:40], exp[39:22], exp[21:20], exp[19:18]);
        end
    endtask

    function automatic logic [59:0] outs();
        return {b_out, b_drv, a_out, a_drv, contention, 18'h0};
    endfunction

    function automatic logic [59:0] mk(input logic [17:0] eb, input logic [1:0] ebd,
                                       input logic [17:0] ea, input logic [1:0] ead,
                                       input logic [1:0] ec);
        return {eb, ebd, ea, ead, ec, 18'h0};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: storage zero after reset; enable both sides with busy inputs.
        ab_oe_n = 2'b00; ba_oe_n = 2'b00; a_in = 18'h3FFFF; b_in = 18'h2AAAA;
        @(posedge clk); #1;
        check("R1", outs(), mk(18'h0, 2'b11, 18'h0, 2'b11, 2'b11));
        @(negedge clk);
        ab_oe_n = 2'b11; ba_oe_n = 2'b11;
        @(posedge clk); #1;
        // R5: released ports
        check("R5", outs(), mk(18'h0, 2'b00, 18'h0, 2'b00, 2'b00));

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            wide_mode = VECS[i].wide;
            ab_oe_n = VECS[i].ab_oe_n; ab_le = VECS[i].ab_le; ab_ck = VECS[i].ab_ck;
            ba_oe_n = VECS[i].ba_oe_n; ba_le = VECS[i].ba_le; ba_ck = VECS[i].ba_ck;
            a_in = VECS[i].a; b_in = VECS[i].b;
            @(posedge clk); #1;
            check($sformatf("%s", VECS[i].tag), outs(),
                  mk(VECS[i].exp_b, VECS[i].exp_bdrv, VECS[i].exp_a, VECS[i].exp_adrv, VECS[i].exp_cont));
        end

        // R2: transparency visible before any clk edge
        @(negedge clk);
        wide_mode = 1'b0; ab_oe_n = 2'b00; ab_le = 2'b11; a_in = 18'h0F0F0;
        ba_oe_n = 2'b11;
        #1;
        check("R2", outs(), mk(18'h0F0F0, 2'b11, 18'h0, 2'b00, 2'b00));
        // R6: B-to-A transparency on its own controls
        ab_oe_n = 2'b11; ba_oe_n = 2'b00; ba_le = 2'b11; b_in = 18'h30303;
        #1;
        check("R6", outs(), mk(18'h0, 2'b00, 18'h30303, 2'b11, 2'b00));

        // R10: latch enable falls, last sampled value retained
        @(negedge clk);
        ab_oe_n = 2'b00; ab_le = 2'b11; a_in = 18'h1ABCD; ba_le = 2'b00;
        @(posedge clk);
        @(negedge clk);
        ab_le = 2'b00; a_in = 18'h00001;
        @(posedge clk); #1;
        check("R10", outs(), mk(18'h1ABCD, 2'b11, 18'h30303, 2'b11, 2'b11));

        // R1: reset in mid operation clears both stores
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", outs(), mk(18'h0, 2'b11, 18'h0, 2'b11, 2'b11));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: act running exp finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule